// File: doc/BRIEF.md
# Paged 32-bit Switch Register Bridge

This block lets a controller read and write 32-bit registers inside an Ethernet switch whose only path is a 16-bit management bus. A 32-bit access becomes three management transactions. The first is a page write that selects the switch register window. The next two move the two 16-bit halves of the data. The target PHY and register numbers for the halves come from the middle bits of the register address.

The upstream side takes one request at a time: an address, a write flag and write data. The block pulses a done flag when the access completes, and presents the assembled 32-bit value on a read. The downstream side drives the command port of an existing management-bus master: a start pulse, a write flag, PHY and register numbers and write data. It watches the master's busy flag and read data.

One register in the switch needs its halves written low first. For a write to that exact address the block reverses its usual half order.

Top module: `swreg_page_bridge`

## Requirements
- R1: Every accepted request produces exactly three downstream transactions. The first is always a write to PHY 0x18, register 0, with data equal to the request address shifted right by 9 and zero-extended to 16 bits.
- R2: The two data transactions both use PHY number 0x10 OR address bits [8:6], a value in the range 0x10 to 0x17.
- R3: The low data half uses register number {address[5:2], 0}. The high half uses that number plus one.
- R4: A read issues two read transactions, low half first and then high half. It returns {high result, low result} as the 32-bit read data.
- R5: A write to any address other than 0x98 sends write data [31:16] to the high register first, then write data [15:0] to the low register.
- R6: A write to exactly address 0x98 sends the low half first and the high half second. Reads of 0x98, and writes to other addresses with the same low bits (such as 0x298), keep the normal order.
- R7: The start flag is a single-cycle pulse. A new transaction starts only after the master has shown busy low. Busy is first examined two cycles after a start.
- R8: Done is high for exactly one cycle, one cycle after the third transaction's busy is seen low. Read data is valid in that cycle.
- R9: A request presented while a sequence is in progress is ignored. It adds no transaction and does not change the running sequence's addresses or data.
- R10: After reset, done and start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Switch register byte address |
| req_wdata | input | 32 | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with req_done |
| mdio_start | output | 1 | Transaction start pulse to the bus master |
| mdio_write | output | 1 | 1 = write transaction, 0 = read |
| mdio_phy | output | 5 | Target PHY address |
| mdio_reg | output | 5 | Target register number |
| mdio_wdata | output | 16 | Write data for the transaction |
| mdio_busy | input | 1 | Bus master busy |
| mdio_rdata | input | 16 | Read data from the bus master |

## Verification
The bench goes after the half-order special case at 0x98. It also checks its look-alikes: the read of 0x98, the neighbour 0x9A and 0x298, which differs only in the page bits. A design that matched on the low address bits alone, or that swapped the order for reads, would log the halves in the wrong order. A sweep over several hundred scattered addresses, with bus latencies from one to four cycles, catches a wrong PHY bit slice, a wrong register parity, or a page shift that is off by one. Requests injected in the middle of a sequence would show up as a fourth transaction or as changed fields if the block accepted them. The done pulse is checked for width, because a design that stayed in its final state would hold done for two cycles.

// File: rtl/swreg_page_bridge.sv
module swreg_page_bridge #(
  parameter int              ADDR_W       = 19,
  parameter logic [4:0]      PAGE_PHY     = 5'h18,
  parameter logic [4:0]      PAGE_REG     = 5'h00,
  parameter logic [ADDR_W-1:0] SPECIAL_ADDR = 'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_done,
  output logic [31:0]       req_rdata,
  output logic              mdio_start,
  output logic              mdio_write,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic              mdio_busy,
  input  logic [15:0]       mdio_rdata
);

  localparam int LAST_STEP = 2;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_GAP, S_WAIT, S_DONE} state_t;

  state_t            state;
  logic [1:0]        step;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [31:0]       wdata_q;
  logic [31:0]       rdata_q;

  wire first_hi = wr_q && (addr_q != SPECIAL_ADDR);
  wire cur_hi   = (step == 2'd1) ? first_hi : !first_hi;
  wire is_page  = (step == 2'd0);

  assign mdio_start = (state == S_ISSUE);
  assign mdio_write = is_page || wr_q;
  assign mdio_phy   = is_page ? PAGE_PHY : {2'b10, addr_q[8:6]};
  assign mdio_reg   = is_page ? PAGE_REG : {addr_q[5:2], cur_hi};
  assign mdio_wdata = is_page ? 16'(addr_q >> 9)
                    : (cur_hi ? wdata_q[31:16] : wdata_q[15:0]);
  assign req_done   = (state == S_DONE);
  assign req_rdata  = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      step    <= 2'd0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          step    <= 2'd0;
          state   <= S_ISSUE;
        end
        S_ISSUE: state <= S_GAP;
        S_GAP:   state <= S_WAIT;
        S_WAIT: if (!mdio_busy) begin
          if (!is_page && !wr_q) begin
            if (cur_hi) rdata_q[31:16] <= mdio_rdata;
            else        rdata_q[15:0]  <= mdio_rdata;
          end
          if (step == 2'(LAST_STEP)) state <= S_DONE;
          else begin
            step  <= step + 2'd1;
            state <= S_ISSUE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [1:0] starts_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) starts_seen <= 2'd0;
    else if (state == S_IDLE) starts_seen <= 2'd0;
    else if (mdio_start) starts_seen <= starts_seen + 2'd1;
  end

  AST_THREE_TRANSFERS: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> starts_seen == 2'd3); // R1
  AST_DATA_PHY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_start && step != 2'd0) |-> mdio_phy[4:3] == 2'b10); // R2
  AST_START_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_start |-> !mdio_busy); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_start |=> !mdio_start); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R8
  AST_HOLD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> ($stable(addr_q) && $stable(wdata_q))); // R9

endmodule

// File: tb/swreg_page_bridge_test.sv
`timescale 1ns/1ps
module swreg_page_bridge_test;
  localparam int AW = 19;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_done;
  logic [31:0] req_rdata;
  logic mdio_start, mdio_write;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata;
  logic mdio_busy = 0;
  logic [15:0] mdio_rdata = '0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  swreg_page_bridge #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
    .req_rdata(req_rdata), .mdio_start(mdio_start), .mdio_write(mdio_write),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_busy(mdio_busy), .mdio_rdata(mdio_rdata));

  function automatic logic [15:0] bus_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h15};
  endfunction

  int n_log = 0;
  int ntx = 0;
  int lat_cnt = 0;
  logic       lg_wr [8];
  logic [4:0] lg_phy[8];
  logic [4:0] lg_reg[8];
  logic [15:0] lg_wd[8];

  always @(posedge clk) begin
    if (mdio_start) begin
      if (n_log < 8) begin
        lg_wr[n_log] = mdio_write; lg_phy[n_log] = mdio_phy;
        lg_reg[n_log] = mdio_reg;  lg_wd[n_log] = mdio_wdata;
      end
      n_log = n_log + 1;
      ntx = ntx + 1;
      mdio_busy <= 1'b1;
      lat_cnt = ntx % 4;
      mdio_rdata <= bus_val(mdio_phy, mdio_reg);
    end else if (mdio_busy) begin
      if (lat_cnt == 0) mdio_busy <= 1'b0;
      else lat_cnt = lat_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a,
                        input logic [31:0] wd, input bit inject);
    logic [4:0] p, rl, rh;
    bit hi_first, seen;
    int k;
    p  = {2'b10, a[8:6]};
    rl = {a[5:2], 1'b0};
    rh = {a[5:2], 1'b1};
    hi_first = wr && (a != AW'('h98));
    @(negedge clk);
    n_log = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    seen = 0;
    for (int c = 0; c < 200 && !seen; c++) begin
      if (inject && c == 2) begin
        req_valid = 1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
      end
      if (inject && c == 5) req_valid = 0;
      if (req_done) seen = 1; else @(negedge clk);
    end
    chk(seen, "R8", "done seen", 32'(seen), 1);
    if (!wr) chk(req_rdata == {bus_val(p, rh), bus_val(p, rl)}, "R4", "read data",
                 req_rdata, {bus_val(p, rh), bus_val(p, rl)});
    @(negedge clk);
    chk(!req_done, "R8", "done one cycle", 32'(req_done), 0);
    chk(n_log == 3, inject ? "R9" : "R1", "transaction count", 32'(n_log), 3);
    if (n_log == 3) begin
      chk(lg_wr[0] && lg_phy[0] == 5'h18 && lg_reg[0] == 5'h0, "R1", "page target",
          {lg_wr[0], lg_phy[0], lg_reg[0]}, {1'b1, 5'h18, 5'h0});
      chk(lg_wd[0] == 16'(a >> 9), "R1", "page value", 32'(lg_wd[0]), 32'(a >> 9));
      for (k = 1; k <= 2; k++) begin
        logic want_hi;
        want_hi = (k == 1) ? hi_first : !hi_first;
        chk(lg_phy[k] == p, "R2", "data phy", 32'(lg_phy[k]), 32'(p));
        chk(lg_reg[k] == (want_hi ? rh : rl), (a == AW'('h98) && wr) ? "R6" : (wr ? "R5" : "R3"),
            "data reg", 32'(lg_reg[k]), 32'(want_hi ? rh : rl));
        chk(lg_wr[k] == wr, "R4", "data direction", 32'(lg_wr[k]), 32'(wr));
        if (wr) chk(lg_wd[k] == (want_hi ? wd[31:16] : wd[15:0]), "R5", "data half",
                    32'(lg_wd[k]), 32'(want_hi ? wd[31:16] : wd[15:0]));
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_done && !mdio_start, "R10", "reset outputs", {req_done, mdio_start}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!req_done && !mdio_start, "R10", "idle outputs", {req_done, mdio_start}, 0);
    access(1, 'h98, 32'h1234_ABCD, 0);    // R6 special write
    access(0, 'h98, 32'h0, 0);            // R6 read keeps order
    access(1, 'h9A, 32'hDEAD_BEEF, 0);    // R6 neighbour, normal order
    access(1, 'h298, 32'hCAFE_F00D, 0);   // R6 other page
    access(0, 'h10C, 32'h0, 0);           // R4
    access(1, 'h7FFFF, 32'hFFFF_0000, 1); // R9 with injection
    access(0, 'h0, 32'h0, 1);             // R9
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 20011 + 7 * i * i);
      access(i[0], a, 32'(i) * 32'h9E37_79B1, (i % 17) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule